// File: doc/BRIEF.md
# Chained Descriptor DMA Engine

This block walks a list of 16-byte descriptors held in system memory and moves the data each one points at, either from memory out to a transmit stream or from a receive stream into memory. A descriptor is four 32-bit words at increasing addresses:

- word 0 holds the flags;
- word 1 holds the buffer length in bytes;
- word 2 holds the buffer address;
- word 3 holds an optional link to the next descriptor.

Software prepares the list, sets the ownership flag in every descriptor it hands over, programs the list head on `desc_base`, and pulses `kick`. The engine fetches each descriptor and checks that the engine owns it. It then moves the buffer one 32-bit word at a time. When the buffer is done, it writes word 0 back with ownership returned to software and then moves on to the next descriptor. It stops after a descriptor flagged as final, or when it meets a descriptor it does not own.

Both the memory master and the two data streams use valid/ready handshakes. A transfer happens on a clock edge where valid and ready are both high. A source that raises valid must hold valid and its payload unchanged until ready is seen. A sink may drop ready at any time to stall the engine. The memory master has at most one read outstanding. A read response arrives one or more cycles after the request is accepted and is taken without back-pressure. A write completes on acceptance. The 8-bit mode register provides three controls: an engine enable, a stored fixed-burst hint, and a self-clearing soft reset that abandons the walk in progress.

Top module: `desc_chain_dma`

## Requirements
- R1: After `rst_n` is released the engine is idle: `busy`, `irq`, `chain_done`, `unavail`, `mem_req_valid`, `tx_valid` and `rx_ready` are all 0, and `mode_q` reads 0.
- R2: A write to the mode register stores enable at bit 7 and fixed-burst at bit 1, which read back at the same positions of `mode_q`. Writing 1 to bit 0 stops any walk at once, with no write-back and no interrupt. Bit 0 then reads 1 for exactly one cycle and returns to 0 by itself. A `kick` in the cycle where bit 0 reads 1 is ignored.
- R3: A `kick` is ignored while the enable bit is 0 or while the engine is busy.
- R4: The engine reads words 0 to 3 of a descriptor from its address upward. If word 0 bit 31 (ownership) is 0, the engine stops, sets `unavail` until the next accepted `kick`, moves no data and does not write that descriptor back.
- R5: The byte length is word 1 bits 12:0, and the engine moves ceil(length/4) 32-bit words starting at the word 2 address. A length of 0 moves nothing. Word 1 bits 31:13 are ignored.
- R6: The `dir_rx` value sampled at the accepted `kick` sets the direction for the whole walk: 0 reads memory and sends it on the tx stream, 1 writes rx stream words to memory. The words keep their order and both streams honour back-pressure.
- R7: After a buffer completes, the engine writes word 0 back to the descriptor address with bit 31 cleared and all other bits unchanged. It does this before it fetches anything further.
- R8: The next descriptor address is chosen in priority order. If word 0 bit 4 (chained) is set, it is word 3. Otherwise, if bit 5 (end of ring) is set, it is the list head. Otherwise it is the current address plus 16.
- R9: After the write-back of a descriptor with word 0 bit 2 (final) set, `chain_done` pulses for one cycle and the engine returns to idle.
- R10: `irq` pulses for one cycle on each descriptor write-back, unless word 0 bit 1 (interrupt suppress) is set. On a final descriptor it always pulses.
- R11: A memory request held with `mem_req_ready` low keeps its address and direction unchanged. At most one read is outstanding at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_we | input | 1 | Mode register write strobe |
| mode_wdata | input | 32 | Mode register write data |
| mode_q | output | 32 | Mode register read value |
| desc_base | input | ADDR_W | Address of the first descriptor |
| kick | input | 1 | Start a walk from `desc_base` |
| dir_rx | input | 1 | Direction: 1 stream to memory, 0 memory to stream |
| busy | output | 1 | A walk is in progress |
| unavail | output | 1 | The last walk stopped on a descriptor the engine did not own |
| irq | output | 1 | Per-descriptor completion pulse |
| chain_done | output | 1 | Final descriptor completed |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_write | output | 1 | 1 write, 0 read |
| mem_req_addr | output | ADDR_W | Byte address, word aligned |
| mem_req_wdata | output | 32 | Write data |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data |
| tx_valid | output | 1 | Transmit stream valid |
| tx_ready | input | 1 | Transmit stream ready |
| tx_data | output | 32 | Transmit stream data |
| rx_valid | input | 1 | Receive stream valid |
| rx_ready | output | 1 | Receive stream ready |
| rx_data | input | 32 | Receive stream data |

## Verification
A wrong word index or a wrong next-address choice shows up at the memory port within the next descriptor fetch. It appears as a write-back landing on the wrong word or a fetch from an address the list never named, so the bench compares every write-back and every buffer word after each walk. A length counter that is off by one moves one word too many or too few. The bench catches it through the sentinel word after each receive buffer and through the tx word count, by the end of that descriptor. A wrong interrupt decision is seen as a mismatch between the `irq` count and the count the suppress and final flags predict, once the walk ends.

// File: rtl/dma_pkg.sv
package dma_pkg;
  localparam int unsigned WORD_W     = 32;
  localparam int unsigned DESC_WORDS = 4;
  localparam int unsigned DESC_BYTES = DESC_WORDS * (WORD_W / 8);

  // word 0 flag positions
  localparam int unsigned OWN_BIT = 31;
  localparam int unsigned RING_BIT = 5;
  localparam int unsigned LINK_BIT = 4;
  localparam int unsigned FINAL_BIT = 2;
  localparam int unsigned QUIET_BIT = 1;

  typedef enum logic [3:0] {
    ST_IDLE, ST_FREQ, ST_FWAIT, ST_LOAD, ST_RX, ST_TREQ, ST_TWAIT, ST_TOUT, ST_WB
  } walk_state_e;

  typedef struct packed {
    logic ring;
    logic link;
    logic final_d;
    logic quiet;
  } desc_flags_t;

  function automatic desc_flags_t decode_flags(input logic [WORD_W-1:0] w0);
    desc_flags_t f;
    f.ring    = w0[RING_BIT];
    f.link    = w0[LINK_BIT];
    f.final_d = w0[FINAL_BIT];
    f.quiet   = w0[QUIET_BIT];
    return f;
  endfunction
endpackage

// File: rtl/dma_mode_reg.sv
module dma_mode_reg
  import dma_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [WORD_W-1:0] wdata,
  output logic              enable,
  output logic              srst_q,
  output logic              abort,
  output logic [WORD_W-1:0] mode_q
);
  logic fixed_burst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable      <= 1'b0;
      fixed_burst <= 1'b0;
      srst_q      <= 1'b0;
    end else if (we) begin
      enable      <= wdata[7];
      fixed_burst <= wdata[1];
      srst_q      <= wdata[0];
    end else begin
      srst_q      <= 1'b0;
    end
  end

  assign abort  = we & wdata[0];
  assign mode_q = {{(WORD_W-8){1'b0}}, enable, 5'b0, fixed_burst, srst_q};

  logic unused_ok;
  assign unused_ok = &{1'b0, wdata[WORD_W-1:8], wdata[6:2]};
endmodule

// File: rtl/dma_desc_latch.sv
module dma_desc_latch
  import dma_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned SIZE_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic [1:0]        cap_idx,
  input  logic [WORD_W-1:0] cap_data,
  output logic [WORD_W-1:0] word0,
  output logic [SIZE_W-1:0] byte_len,
  output logic [ADDR_W-1:0] buf_addr,
  output logic [ADDR_W-1:0] link_addr
);
  logic [WORD_W-1:0] words [DESC_WORDS];

  for (genvar i = 0; i < DESC_WORDS; i++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        words[i] <= '0;
      else if (cap_en && (cap_idx == 2'(i)))
        words[i] <= cap_data;
    end
  end

  assign word0     = words[0];
  assign byte_len  = words[1][SIZE_W-1:0];
  assign buf_addr  = words[2][ADDR_W-1:0];
  assign link_addr = words[3][ADDR_W-1:0];

  logic unused_ok;
  assign unused_ok = &{1'b0, words[1][WORD_W-1:SIZE_W]};
endmodule

// File: rtl/dma_beat_ctr.sv
module dma_beat_ctr #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned SIZE_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  input  logic [SIZE_W-1:0] byte_len,
  input  logic [ADDR_W-1:0] start_addr,
  output logic [ADDR_W-1:0] ptr,
  output logic              left_zero,
  output logic              last_beat
);
  localparam int unsigned CNT_W = SIZE_W - 1;

  logic [CNT_W-1:0] left;
  logic [SIZE_W:0]  rounded;

  assign rounded = {1'b0, byte_len} + (SIZE_W+1)'(3);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left <= '0;
      ptr  <= '0;
    end else if (load) begin
      left <= rounded[SIZE_W:2];
      ptr  <= start_addr;
    end else if (step) begin
      left <= left - CNT_W'(1);
      ptr  <= ptr + ADDR_W'(4);
    end
  end

  assign left_zero = (left == '0);
  assign last_beat = (left == CNT_W'(1));
endmodule

// File: rtl/dma_walker.sv
module dma_walker
  import dma_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              abort,
  input  logic              srst_q,
  input  logic              enable,
  input  logic              kick,
  input  logic              dir_rx,
  input  logic [ADDR_W-1:0] desc_base,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_write,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [WORD_W-1:0] mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [WORD_W-1:0] mem_rsp_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [WORD_W-1:0] tx_data,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [WORD_W-1:0] rx_data,
  input  logic [WORD_W-1:0] word0,
  input  logic [ADDR_W-1:0] link_addr,
  input  logic [ADDR_W-1:0] ptr,
  input  logic              left_zero,
  input  logic              last_beat,
  output logic              cap_en,
  output logic [1:0]        cap_idx,
  output logic              ctr_load,
  output logic              ctr_step,
  output logic              busy,
  output logic              unavail,
  output logic              irq,
  output logic              chain_done
);
  walk_state_e       state, state_nx;
  logic [ADDR_W-1:0] cur_addr, base_q;
  logic [1:0]        widx;
  logic              dir_q;
  logic [WORD_W-1:0] hold;
  desc_flags_t       fl;
  logic              req_fire, wb_fire, start;
  logic [ADDR_W-1:0] next_addr;

  assign fl       = decode_flags(word0);
  assign req_fire = mem_req_valid & mem_req_ready;
  assign wb_fire  = (state == ST_WB) & mem_req_ready;
  assign start    = (state == ST_IDLE) & kick & enable & ~abort & ~srst_q;

  always_comb begin
    if (fl.link)      next_addr = link_addr;
    else if (fl.ring) next_addr = base_q;
    else              next_addr = cur_addr + ADDR_W'(DESC_BYTES);
  end

  // request and stream drive
  always_comb begin
    mem_req_valid = 1'b0;
    mem_req_write = 1'b0;
    mem_req_addr  = '0;
    mem_req_wdata = '0;
    rx_ready      = 1'b0;
    tx_valid      = 1'b0;
    unique case (state)
      ST_FREQ: begin
        mem_req_valid = 1'b1;
        mem_req_addr  = cur_addr + ADDR_W'({widx, 2'b00});
      end
      ST_RX: begin
        mem_req_valid = rx_valid & ~left_zero;
        mem_req_write = 1'b1;
        mem_req_addr  = ptr;
        mem_req_wdata = rx_data;
        rx_ready      = mem_req_ready & ~left_zero;
      end
      ST_TREQ: begin
        mem_req_valid = ~left_zero;
        mem_req_addr  = ptr;
      end
      ST_TOUT: tx_valid = 1'b1;
      ST_WB: begin
        mem_req_valid = 1'b1;
        mem_req_write = 1'b1;
        mem_req_addr  = cur_addr;
        mem_req_wdata = word0 & ~(WORD_W'(1) << OWN_BIT);
      end
      default: ;
    endcase
  end

  assign tx_data    = hold;
  assign cap_en     = (state == ST_FWAIT) & mem_rsp_valid;
  assign cap_idx    = widx;
  assign ctr_load   = (state == ST_LOAD);
  assign ctr_step   = ((state == ST_RX) & req_fire) | ((state == ST_TOUT) & tx_ready);
  assign busy       = (state != ST_IDLE);
  assign irq        = wb_fire & (fl.final_d | ~fl.quiet);
  assign chain_done = wb_fire & fl.final_d;

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE:  if (start) state_nx = ST_FREQ;
      ST_FREQ:  if (req_fire) state_nx = ST_FWAIT;
      ST_FWAIT: if (mem_rsp_valid) begin
        if ((widx == 2'd0) && !mem_rsp_data[OWN_BIT]) state_nx = ST_IDLE;
        else if (widx == 2'd3)                         state_nx = ST_LOAD;
        else                                           state_nx = ST_FREQ;
      end
      ST_LOAD:  state_nx = dir_q ? ST_RX : ST_TREQ;
      ST_RX: begin
        if (left_zero) state_nx = ST_WB;
        else if (req_fire && last_beat) state_nx = ST_WB;
      end
      ST_TREQ: begin
        if (left_zero) state_nx = ST_WB;
        else if (req_fire) state_nx = ST_TWAIT;
      end
      ST_TWAIT: if (mem_rsp_valid) state_nx = ST_TOUT;
      ST_TOUT:  if (tx_ready) state_nx = last_beat ? ST_WB : ST_TREQ;
      ST_WB:    if (wb_fire) state_nx = fl.final_d ? ST_IDLE : ST_FREQ;
      default:  state_nx = ST_IDLE;
    endcase
    if (abort) state_nx = ST_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cur_addr <= '0;
      base_q   <= '0;
      widx     <= '0;
      dir_q    <= 1'b0;
      hold     <= '0;
      unavail  <= 1'b0;
    end else begin
      state <= state_nx;
      if (start) begin
        cur_addr <= desc_base;
        base_q   <= desc_base;
        dir_q    <= dir_rx;
        widx     <= '0;
        unavail  <= 1'b0;
      end
      if ((state == ST_FWAIT) && mem_rsp_valid && !abort) begin
        if ((widx == 2'd0) && !mem_rsp_data[OWN_BIT]) unavail <= 1'b1;
        else widx <= widx + 2'd1;
      end
      if ((state == ST_TWAIT) && mem_rsp_valid) hold <= mem_rsp_data;
      if (wb_fire && !fl.final_d) begin
        cur_addr <= next_addr;
        widx     <= '0;
      end
    end
  end
endmodule

// File: rtl/desc_chain_dma.sv
module desc_chain_dma
  import dma_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned SIZE_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_we,
  input  logic [31:0]       mode_wdata,
  output logic [31:0]       mode_q,
  input  logic [ADDR_W-1:0] desc_base,
  input  logic              kick,
  input  logic              dir_rx,
  output logic              busy,
  output logic              unavail,
  output logic              irq,
  output logic              chain_done,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_write,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [31:0]       mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [31:0]       mem_rsp_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [31:0]       tx_data,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [31:0]       rx_data
);
  logic              enable, srst_q, abort;
  logic              cap_en, ctr_load, ctr_step, left_zero, last_beat;
  logic [1:0]        cap_idx;
  logic [WORD_W-1:0] word0;
  logic [SIZE_W-1:0] byte_len;
  logic [ADDR_W-1:0] buf_addr, link_addr, ptr;

  dma_mode_reg u_mode (
    .clk(clk), .rst_n(rst_n), .we(mode_we), .wdata(mode_wdata),
    .enable(enable), .srst_q(srst_q), .abort(abort), .mode_q(mode_q)
  );

  dma_desc_latch #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_desc (
    .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .cap_idx(cap_idx),
    .cap_data(mem_rsp_data), .word0(word0), .byte_len(byte_len),
    .buf_addr(buf_addr), .link_addr(link_addr)
  );

  dma_beat_ctr #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_beat (
    .clk(clk), .rst_n(rst_n), .load(ctr_load), .step(ctr_step),
    .byte_len(byte_len), .start_addr(buf_addr), .ptr(ptr),
    .left_zero(left_zero), .last_beat(last_beat)
  );

  dma_walker #(.ADDR_W(ADDR_W)) u_walk (
    .clk(clk), .rst_n(rst_n), .abort(abort), .srst_q(srst_q), .enable(enable),
    .kick(kick), .dir_rx(dir_rx), .desc_base(desc_base),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .word0(word0), .link_addr(link_addr), .ptr(ptr), .left_zero(left_zero),
    .last_beat(last_beat), .cap_en(cap_en), .cap_idx(cap_idx),
    .ctr_load(ctr_load), .ctr_step(ctr_step), .busy(busy), .unavail(unavail),
    .irq(irq), .chain_done(chain_done)
  );
endmodule

// File: rtl/dma_chain_checker.sv
module dma_chain_checker #(
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mode_we,
  input logic [31:0]       mode_wdata,
  input logic [31:0]       mode_q,
  input logic              busy,
  input logic              unavail,
  input logic              irq,
  input logic              chain_done,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic              mem_req_write,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic [31:0]       mem_req_wdata,
  input logic              mem_rsp_valid,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic [31:0]       tx_data,
  input logic              rx_ready
);
  logic rd_pending;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_pending <= 1'b0;
    else if (mem_req_valid && mem_req_ready && !mem_req_write) rd_pending <= 1'b1;
    else if (mem_rsp_valid) rd_pending <= 1'b0;
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n || mode_q[0])
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write)); // R11
  AST_ONE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rd_pending |-> !(mem_req_valid && !mem_req_write)); // R11
  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n || mode_q[0])
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data)); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req_valid && !tx_valid && !rx_ready && !irq && !chain_done); // R1
  AST_UNAVAIL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    unavail |-> !busy || !mem_req_write); // R4
  AST_SRST_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q[0] && !(mode_we && mode_wdata[0]) |=> !mode_q[0]); // R2
  AST_SRST_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q[0] |-> !busy); // R2
  AST_WB_CLEARS_OWN: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> mem_req_write && mem_req_ready && !mem_req_wdata[31]); // R7
  AST_DONE_WITH_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    chain_done |-> irq); // R10
  AST_DONE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    chain_done |=> !busy); // R9
endmodule

bind desc_chain_dma dma_chain_checker #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_desc_chain_dma.sv
`timescale 1ns/1ps
module sim_desc_chain_dma;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_we = 1'b0;
  logic [31:0] mode_wdata = '0;
  logic [31:0] mode_q;
  logic [31:0] desc_base = '0;
  logic        kick = 1'b0, dir_rx = 1'b0;
  logic        busy, unavail, irq, chain_done;
  logic        mem_req_valid, mem_req_ready, mem_req_write;
  logic [31:0] mem_req_addr, mem_req_wdata;
  logic        mem_rsp_valid;
  logic [31:0] mem_rsp_data;
  logic        tx_valid, tx_ready, rx_valid, rx_ready;
  logic [31:0] tx_data, rx_data;

  always #2 clk = ~clk;

  desc_chain_dma u0 (.*);

  int nchk = 0, nfail = 0;
  logic [31:0] mem [4096];
  logic [31:0] src [4096];
  logic [31:0] cap [4096];
  int ncap = 0, src_idx = 0, irq_cnt = 0, done_cnt = 0, viol = 0;
  logic        bd_we = 1'b0;
  logic [31:0] bd_addr = '0, bd_data = '0;
  logic        pend = 1'b0;
  int          lat = 0;
  logic [11:0] paddr = '0;

  // memory model: random ready, 1..3 cycle read latency
  always @(posedge clk) begin
    if (!rst_n) begin
      mem_req_ready <= 1'b0; mem_rsp_valid <= 1'b0; pend <= 1'b0;
    end else begin
      mem_rsp_valid <= 1'b0;
      if (bd_we) mem[bd_addr[13:2]] <= bd_data;
      if (mem_req_valid && mem_req_ready) begin
        if (mem_req_write) mem[mem_req_addr[13:2]] <= mem_req_wdata;
        else begin
          if (pend) viol <= viol + 1;
          pend <= 1'b1; lat <= int'($urandom % 3); paddr <= mem_req_addr[13:2];
        end
      end else if (pend) begin
        if (lat == 0) begin
          mem_rsp_valid <= 1'b1; mem_rsp_data <= mem[paddr]; pend <= 1'b0;
        end else lat <= lat - 1;
      end
      mem_req_ready <= ($urandom % 4) != 0;
    end
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      tx_ready <= 1'b0; rx_valid <= 1'b0;
    end else begin
      if (tx_valid && tx_ready) begin cap[ncap % 4096] <= tx_data; ncap <= ncap + 1; end
      tx_ready <= ($urandom % 3) != 0;
      if (rx_valid && rx_ready) begin
        src_idx <= src_idx + 1; rx_valid <= ($urandom % 3) != 0;
      end else if (!rx_valid) rx_valid <= ($urandom % 3) != 0;
      if (irq) irq_cnt <= irq_cnt + 1;
      if (chain_done) done_cnt <= done_cnt + 1;
    end
  end
  assign rx_data = src[src_idx % 4096];

  initial begin
    repeat (190000) @(posedge clk);
    $display("FAIL watchdog act=running exp=finished");
    $display("  == %0d vectors applied, %0d miscompares ==", nchk + 1, nfail + 1);
    $finish;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic bd_write(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk); bd_we = 1'b1; bd_addr = a; bd_data = d;
    @(negedge clk); bd_we = 1'b0;
  endtask

  task automatic mode_write(input logic [31:0] d);
    @(negedge clk); mode_we = 1'b1; mode_wdata = d;
    @(negedge clk); mode_we = 1'b0;
  endtask

  task automatic put_desc(input logic [31:0] a, input logic [31:0] w0, input logic [31:0] w1,
                          input logic [31:0] w2, input logic [31:0] w3);
    bd_write(a, w0); bd_write(a + 4, w1); bd_write(a + 8, w2); bd_write(a + 12, w3);
  endtask

  function automatic int nwords(input int sz);
    return (sz + 3) / 4;
  endfunction

  task automatic kick_and_wait(input logic [31:0] base, input bit rx, output bit ok);
    @(negedge clk); desc_base = base; dir_rx = rx; kick = 1'b1;
    @(negedge clk); kick = 1'b0;
    ok = 1'b0;
    for (int i = 0; i < 20000; i++) begin
      if (!busy) begin ok = 1'b1; break; end
      @(negedge clk);
    end
    repeat (4) @(negedge clk);
  endtask

  int          g_sz [4];
  bit          g_dic [4];
  logic [31:0] d_addr [4], b_addr [4], w0v [4];

  task automatic run_chain(input int nd, input bit rx, input bit chained, input int stop);
    int eff, exp_irq, s0, c0, i0, dn0, k, bad;
    bit ok;
    logic [31:0] w1, w3, fa, fe;
    eff = (stop < 0) ? nd : stop;
    for (int i = 0; i < nd; i++) begin
      d_addr[i] = chained ? (32'h400 + 32'((nd - 1 - i) * 'h50)) : (32'h100 + 32'(i * 16));
      b_addr[i] = (nd == 1 && g_sz[0] > 1000) ? 32'h1000 : (32'h1000 + 32'(i * 'h400));
    end
    for (int i = 0; i < nd; i++) begin
      w0v[i] = {(i != stop), 1'($urandom), 24'h0, 1'b0, chained, (i == 0), (i == nd - 1), g_dic[i], 1'b0};
      w1 = {$urandom} << 13 | 32'(g_sz[i]);
      w3 = chained ? ((i == nd - 1) ? 32'h0 : d_addr[i + 1]) : 32'h3000;
      put_desc(d_addr[i], w0v[i], w1, b_addr[i], w3);
      for (int j = 0; j <= nwords(g_sz[i]); j++)
        bd_write(b_addr[i] + 32'(4 * j), rx ? (32'hDEAD0000 + 32'(j)) : $urandom);
    end
    s0 = src_idx; c0 = ncap; i0 = irq_cnt; dn0 = done_cnt;
    kick_and_wait(d_addr[0], rx, ok);
    chk(ok, "R9 walk ends", {31'b0, busy}, 32'h0);
    exp_irq = 0;
    for (int i = 0; i < eff; i++) if (i == nd - 1 || !g_dic[i]) exp_irq++;
    chk(irq_cnt - i0 == exp_irq, "R10 irq count", 32'(irq_cnt - i0), 32'(exp_irq));
    chk(done_cnt - dn0 == ((stop < 0) ? 1 : 0), "R9 chain_done", 32'(done_cnt - dn0), (stop < 0) ? 32'd1 : 32'd0);
    chk(unavail == (stop >= 0), "R4 unavail", {31'b0, unavail}, {31'b0, stop >= 0});
    for (int i = 0; i < eff; i++)
      chk(mem[d_addr[i][13:2]] == (w0v[i] & 32'h7FFFFFFF), "R7 write-back", mem[d_addr[i][13:2]], w0v[i] & 32'h7FFFFFFF);
    if (stop >= 0)
      chk(mem[d_addr[stop][13:2]] == w0v[stop], "R4 not owned untouched", mem[d_addr[stop][13:2]], w0v[stop]);
    k = 0;
    for (int i = 0; i < eff; i++) begin
      bad = 0; fa = '0; fe = '0;
      for (int j = 0; j < nwords(g_sz[i]); j++) begin
        logic [31:0] act, exp;
        if (rx) begin act = mem[(b_addr[i][13:2]) + 12'(j)]; exp = src[(s0 + k) % 4096]; end
        else begin act = cap[(c0 + k) % 4096]; exp = mem[(b_addr[i][13:2]) + 12'(j)]; end
        if (act != exp && bad == 0) begin fa = act; fe = exp; end
        if (act != exp) bad++;
        k++;
      end
      chk(bad == 0, "R6 data", fa, fe);
      if (rx) chk(mem[(b_addr[i][13:2]) + 12'(nwords(g_sz[i]))] == 32'hDEAD0000 + 32'(nwords(g_sz[i])),
                  "R5 length bound", mem[(b_addr[i][13:2]) + 12'(nwords(g_sz[i]))], 32'hDEAD0000 + 32'(nwords(g_sz[i])));
    end
    if (rx) chk(src_idx - s0 == k, "R5 rx word count", 32'(src_idx - s0), 32'(k));
    else chk(ncap - c0 == k, "R5 tx word count", 32'(ncap - c0), 32'(k));
  endtask

  initial begin
    bit ok;
    int c0, i0;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 4096; i++) begin src[i] = $urandom; mem[i] = '0; end
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !irq && !chain_done && !unavail, "R1 idle after reset", {28'b0, busy, irq, chain_done, unavail}, 32'h0);
    chk(mode_q == 32'h0 && !mem_req_valid && !tx_valid && !rx_ready, "R1 outputs after reset", mode_q, 32'h0);

    mode_write(32'h82);
    chk(mode_q == 32'h82, "R2 mode readback", mode_q, 32'h82);

    // R3: disabled engine ignores kick
    mode_write(32'h00);
    put_desc(32'h100, 32'h8000_0004, 32'd8, 32'h1000, 32'h0);
    kick_and_wait(32'h100, 1'b0, ok);
    chk(mem[12'h040] == 32'h8000_0004, "R3 kick ignored when disabled", mem[12'h040], 32'h8000_0004);
    mode_write(32'h80);

    // directed chains
    g_sz[0] = 13; g_sz[1] = 64; g_sz[2] = 7; g_dic[0] = 0; g_dic[1] = 1; g_dic[2] = 0;
    run_chain(3, 1'b0, 1'b1, -1);   // R8 linked, tx
    g_sz[0] = 5; g_sz[1] = 22; g_dic[0] = 1; g_dic[1] = 1;
    run_chain(2, 1'b1, 1'b0, -1);   // R8 sequential, rx, last always interrupts
    g_sz[0] = 0; g_sz[1] = 4; g_dic[0] = 0; g_dic[1] = 0;
    run_chain(2, 1'b0, 1'b1, -1);   // R5 zero length
    g_sz[0] = 9; g_sz[1] = 9; g_sz[2] = 9; g_dic[0] = 0; g_dic[1] = 0; g_dic[2] = 0;
    run_chain(3, 1'b1, 1'b1, 1);    // R4 stop on unowned
    g_sz[0] = 4096; g_dic[0] = 1;
    run_chain(1, 1'b1, 1'b0, -1);   // R5 full buffer

    // R8 end of ring wraps to the list head, which is then no longer owned
    put_desc(32'h100, 32'h8000_0020, 32'd8, 32'h1000, 32'h3000);
    c0 = ncap; i0 = irq_cnt;
    kick_and_wait(32'h100, 1'b0, ok);
    chk(ok && unavail, "R8 ring wrap reaches head", {31'b0, unavail}, 32'h1);
    chk(irq_cnt - i0 == 1 && ncap - c0 == 2, "R8 ring one descriptor moved", 32'(ncap - c0), 32'd2);

    // R2 soft reset aborts a long transfer
    put_desc(32'h100, 32'h8000_0004, 32'd800, 32'h2000, 32'h0);
    i0 = irq_cnt;
    @(negedge clk); desc_base = 32'h100; dir_rx = 1'b0; kick = 1'b1;
    @(negedge clk); kick = 1'b0;
    repeat (40) @(negedge clk);
    chk(busy, "R2 long walk in progress", {31'b0, busy}, 32'h1);
    mode_we = 1'b1; mode_wdata = 32'h81;
    @(negedge clk); mode_we = 1'b0;
    chk(mode_q == 32'h81 && !busy, "R2 soft reset stops walk", mode_q, 32'h81);
    @(negedge clk);
    chk(mode_q == 32'h80, "R2 soft reset self-clears", mode_q, 32'h80);
    repeat (10) @(negedge clk);
    chk(mem[12'h040] == 32'h8000_0004 && irq_cnt == i0, "R2 no write-back after abort", mem[12'h040], 32'h8000_0004);

    // constrained random chains
    for (int it = 0; it < 24; it++) begin
      int nd, stop;
      nd = 1 + int'($urandom % 4);
      for (int i = 0; i < nd; i++) begin g_sz[i] = int'($urandom % 41); g_dic[i] = 1'($urandom); end
      stop = (nd > 1 && ($urandom % 5) == 0) ? 1 + int'($urandom % (nd - 1)) : -1;
      run_chain(nd, 1'($urandom), 1'($urandom), stop);
    end

    chk(viol == 0, "R11 single outstanding read", 32'(viol), 32'h0);
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule